// File: doc/BRIEF.md
# E3 Maintenance Byte Condition Monitor

This block sits behind the frame aligner of a G.832 E3 receiver. Once per received frame the aligner hands it the captured maintenance byte and the number of zero bits counted in that frame, and raises a one-cycle frame strobe. The monitor filters these per-frame samples into four steady status conditions. The conditions are the far-end receive failure indication, the validated timing marker, a payload-type instability flag and the alarm indication signal.

Every change of one of these conditions is latched into a sticky interrupt source register. The same register also captures single-cycle events reported by neighbouring logic: loss of signal, loss of frame, out of frame, frame alignment change and the two synchronisation status message events. A read pulse clears the register. One interrupt line is raised whenever a latched source has its enable bit set. The two synchronisation status message enables have no effect when the older framing revision is selected.

Top module: `e3_maint_monitor`

## Requirements
- R1: The far-end failure status (`ferf_stat`) rises after N consecutive strobed frames carry a 1 in maintenance byte bit 7. N is 3 when `ferf_sel5`=0 and 5 when `ferf_sel5`=1.
- R2: `ferf_stat` falls after N consecutive strobed frames carry a 0 in bit 7, with the same N. A frame that matches the current status restarts the count.
- R3: `tmark_val` takes the value of maintenance byte bit 0 only after 3 (`tmark_sel5`=0) or 5 (`tmark_sel5`=1) consecutive frames carry that same value.
- R4: The payload type is byte bits 5:3. `pld_unstab` becomes 1 on a frame whose payload type differs from the previous frame's. It returns to 0 on the fourth following frame in a row with no change, so that 5 identical frames are seen. It is 0 after reset, and the first frame after reset counts as no change.
- R5: A frame qualifies for AIS when `zero_cnt` < 7. `ais_stat` rises after 2 consecutive qualifying frames and falls after 2 consecutive frames with 7 or more zeros.
- R6: All status outputs and interrupt sources reset to 0. Status outputs change only on a clock edge where `frame_stb` is 1.
- R7: `int_src` bit positions are: 0 AIS change, 1 LOS, 2 LOF, 3 OOF, 4 alignment change, 5 SSM out-of-sequence, 6 SSM message change, 7 always 0, 8 FERF change, 9 timing marker change, 10 payload-instability change. A status change sets its bit on the same edge at which the status updates, and the bit stays set.
- R8: A `src_rd` pulse clears all source bits. A source that sets in the same cycle stays set.
- R9: `irq` is 1 exactly when some source bit is set together with its enable. The enables are `int_en` bits 0 to 6 for sources 0 to 6 and `st_en` bits 0 to 2 for sources 8 to 10. When `old_rev`=1, `int_en` bits 5 and 6 are ignored.
- R10: `aux_evt` bit 0 LOS, bit 1 LOF, bit 2 OOF, bit 3 SSM out-of-sequence, bit 4 SSM message change, together with `align_chg`, set their source bits on any clock edge, with or without a frame strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_stb | input | 1 | One-cycle strobe per received frame |
| maint_byte | input | 8 | Captured maintenance byte of the frame |
| zero_cnt | input | 8 | Zero bits counted in the frame |
| align_chg | input | 1 | Frame alignment change pulse |
| aux_evt | input | 5 | Neighbour event pulses (LOS, LOF, OOF, SSM OOS, SSM msg) |
| ferf_sel5 | input | 1 | FERF persistence: 0 selects 3 frames, 1 selects 5 |
| tmark_sel5 | input | 1 | Timing marker persistence: 0 selects 3, 1 selects 5 |
| old_rev | input | 1 | Older framing revision; masks SSM enables |
| int_en | input | 7 | Enables for sources 0 to 6 |
| st_en | input | 3 | Enables for sources 8 to 10 |
| src_rd | input | 1 | Read pulse that clears the sources |
| ferf_stat | output | 1 | Filtered far-end failure status |
| tmark_val | output | 1 | Validated timing marker |
| pld_unstab | output | 1 | Payload type unstable flag |
| ais_stat | output | 1 | AIS status |
| int_src | output | 11 | Sticky interrupt sources |
| irq | output | 1 | Interrupt request |

## Verification
A source clear by `src_rd` and the setting of a source can fall in the same cycle. The bench raises `src_rd` together with an `align_chg` pulse while other bits are already latched. It then expects only bit 4 to survive. A second collision occurs when a frame strobe and a neighbour event arrive on one edge. Both bits must then be latched, and the status outputs must settle on that edge.

// File: rtl/e3mm_pkg.sv
// Package: source indices and widths shared by the maintenance monitor.
// Assumes the source vector layout documented with the top module.
package e3mm_pkg;
    localparam int NSRC      = 11;
    localparam int SRC_AIS   = 0;
    localparam int SRC_LOS   = 1;
    localparam int SRC_LOF   = 2;
    localparam int SRC_OOF   = 3;
    localparam int SRC_COFA  = 4;
    localparam int SRC_SOOS  = 5;
    localparam int SRC_SMSG  = 6;
    localparam int SRC_FERF  = 8;
    localparam int SRC_TMARK = 9;
    localparam int SRC_PLD   = 10;
    localparam int BIT_FERF  = 7;
    localparam int BIT_TMARK = 0;
    localparam int PT_LO     = 3;
    localparam int PT_W      = 3;
endpackage

// File: rtl/e3mm_persist.sv
// Module: consecutive-frame persistence filter for one status bit.
// The status flips to the sampled value only after LIM consecutive strobed
// samples differ from it; LIM is NA or NB, picked by sel_b. A matching sample
// restarts the run. Assumes din is only meaningful when stb is high.
module e3mm_persist #(
    parameter int NA = 3,
    parameter int NB = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic sel_b,
    input  logic din,
    output logic stat,
    output logic chg
);
    localparam int NMAX = (NA > NB) ? NA : NB;
    localparam int CW   = $clog2(NMAX + 1);

    logic [CW-1:0] cnt_q, cnt_n, lim;
    logic          stat_q, stat_n;

    // Select the run length required for a change
    always_comb lim = sel_b ? CW'(NB) : CW'(NA);

    // Next run count and status for this frame
    always_comb begin
        cnt_n  = cnt_q;
        stat_n = stat_q;
        if (stb) begin
            if (din == stat_q) begin
                cnt_n = '0;
            end else if (cnt_q + 1'b1 == lim) begin
                stat_n = din;
                cnt_n  = '0;
            end else begin
                cnt_n = cnt_q + 1'b1;
            end
        end
    end

    // Register run count and status
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            stat_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_n;
            stat_q <= stat_n;
        end
    end

    assign stat = stat_q;
    assign chg  = (stat_n != stat_q);

    // R6
    stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |=> $stable(stat_q));
    // R1
    run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(NMAX));
endmodule

// File: rtl/e3mm_pld_watch.sv
// Module: payload type stability watcher.
// Flags instability from the frame with a changed payload type until WIN
// identical frames in a row have been seen. Assumes the first frame after
// reset has no predecessor and so counts as unchanged.
module e3mm_pld_watch #(
    parameter int PW  = 3,
    parameter int WIN = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stb,
    input  logic [PW-1:0] pt,
    output logic          unstab,
    output logic          chg
);
    localparam int RUN = WIN - 1;
    localparam int CW  = $clog2(WIN);

    logic [PW-1:0] prev_q;
    logic          have_q;
    logic          uns_q, uns_n;
    logic [CW-1:0] run_q, run_n;

    // Next instability flag and equal-frame run
    always_comb begin
        uns_n = uns_q;
        run_n = run_q;
        if (stb) begin
            if (have_q && pt != prev_q) begin
                uns_n = 1'b1;
                run_n = '0;
            end else if (uns_q) begin
                if (run_q + 1'b1 == CW'(RUN)) begin
                    uns_n = 1'b0;
                    run_n = '0;
                end else begin
                    run_n = run_q + 1'b1;
                end
            end
        end
    end

    // Register previous payload type, flag and run
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            have_q <= 1'b0;
            uns_q  <= 1'b0;
            run_q  <= '0;
        end else begin
            if (stb) begin
                prev_q <= pt;
                have_q <= 1'b1;
            end
            uns_q <= uns_n;
            run_q <= run_n;
        end
    end

    assign unstab = uns_q;
    assign chg    = (uns_n != uns_q);

    // R4
    pld_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && have_q && pt != prev_q) |=> uns_q);
    // R6
    pld_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |=> $stable(uns_q));
endmodule

// File: rtl/e3mm_irq.sv
// Module: sticky interrupt source register and request gating.
// Sources set on any edge where their set bit is high; a read pulse clears
// all bits but loses to a simultaneous set. Assumes en is already masked.
module e3mm_irq #(
    parameter int NSRC = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set,
    input  logic            rd,
    input  logic [NSRC-1:0] en,
    output logic [NSRC-1:0] src,
    output logic            irq
);
    logic [NSRC-1:0] src_q;

    // Latch sources, clear on read, set has priority
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= (rd ? '0 : src_q) | set;
    end

    assign src = src_q;
    assign irq = |(src_q & en);

    // R7
    src_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> ((src_q & $past(src_q)) == $past(src_q)));
    // R8
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && set == '0) |=> src_q == '0);
    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set != '0) |=> ((src_q & $past(set)) == $past(set)));
endmodule

// File: rtl/e3_maint_monitor.sv
// Module: E3 maintenance byte condition monitor (top).
// Filters per-frame maintenance byte fields and zero counts into status
// bits, latches status changes and neighbour events as interrupt sources,
// and gates them into one request. Assumes maint_byte and zero_cnt are
// valid in the cycle frame_stb is high.
module e3_maint_monitor #(
    parameter int ZW        = 8,
    parameter int AIS_ZMIN  = 7,
    parameter int AIS_RUN   = 2,
    parameter int SHORT_RUN = 3,
    parameter int LONG_RUN  = 5,
    parameter int PLD_WIN   = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_stb,
    input  logic [7:0]    maint_byte,
    input  logic [ZW-1:0] zero_cnt,
    input  logic          align_chg,
    input  logic [4:0]    aux_evt,
    input  logic          ferf_sel5,
    input  logic          tmark_sel5,
    input  logic          old_rev,
    input  logic [6:0]    int_en,
    input  logic [2:0]    st_en,
    input  logic          src_rd,
    output logic          ferf_stat,
    output logic          tmark_val,
    output logic          pld_unstab,
    output logic          ais_stat,
    output logic [10:0]   int_src,
    output logic          irq
);
    import e3mm_pkg::*;

    logic            ferf_chg, tm_chg, pld_chg, ais_chg, ais_in;
    logic [NSRC-1:0] set_vec, en_vec;

    // Qualify the frame for AIS by its zero density
    always_comb ais_in = (zero_cnt < ZW'(AIS_ZMIN));

    e3mm_persist #(.NA(SHORT_RUN), .NB(LONG_RUN)) u_ferf (
        .clk(clk), .rst_n(rst_n), .stb(frame_stb), .sel_b(ferf_sel5),
        .din(maint_byte[BIT_FERF]), .stat(ferf_stat), .chg(ferf_chg));

    e3mm_persist #(.NA(SHORT_RUN), .NB(LONG_RUN)) u_tmark (
        .clk(clk), .rst_n(rst_n), .stb(frame_stb), .sel_b(tmark_sel5),
        .din(maint_byte[BIT_TMARK]), .stat(tmark_val), .chg(tm_chg));

    e3mm_persist #(.NA(AIS_RUN), .NB(AIS_RUN)) u_ais (
        .clk(clk), .rst_n(rst_n), .stb(frame_stb), .sel_b(1'b0),
        .din(ais_in), .stat(ais_stat), .chg(ais_chg));

    e3mm_pld_watch #(.PW(PT_W), .WIN(PLD_WIN)) u_pld (
        .clk(clk), .rst_n(rst_n), .stb(frame_stb),
        .pt(maint_byte[PT_LO +: PT_W]), .unstab(pld_unstab), .chg(pld_chg));

    // Assemble the source set vector
    always_comb begin
        set_vec            = '0;
        set_vec[SRC_AIS]   = ais_chg;
        set_vec[SRC_LOS]   = aux_evt[0];
        set_vec[SRC_LOF]   = aux_evt[1];
        set_vec[SRC_OOF]   = aux_evt[2];
        set_vec[SRC_COFA]  = align_chg;
        set_vec[SRC_SOOS]  = aux_evt[3];
        set_vec[SRC_SMSG]  = aux_evt[4];
        set_vec[SRC_FERF]  = ferf_chg;
        set_vec[SRC_TMARK] = tm_chg;
        set_vec[SRC_PLD]   = pld_chg;
    end

    // Assemble enables, masking SSM enables in the older revision
    always_comb begin
        en_vec                    = '0;
        en_vec[6:0]               = int_en;
        en_vec[SRC_SOOS]          = int_en[SRC_SOOS] & ~old_rev;
        en_vec[SRC_SMSG]          = int_en[SRC_SMSG] & ~old_rev;
        en_vec[SRC_PLD:SRC_FERF]  = st_en;
    end

    e3mm_irq #(.NSRC(NSRC)) u_irq (
        .clk(clk), .rst_n(rst_n), .set(set_vec), .rd(src_rd),
        .en(en_vec), .src(int_src), .irq(irq));

    // R7
    unused_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !int_src[7]);
    // R9
    old_rev_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (old_rev && (int_src & {st_en, 1'b0, int_en}) == 11'h060) |-> !irq);
    // R6
    ais_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |=> $stable(ais_stat));
endmodule

// File: tb/e3_maint_monitor_test.sv
module e3_maint_monitor_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_stb = 1'b0;
    logic [7:0]  maint_byte = '0;
    logic [7:0]  zero_cnt = 8'd20;
    logic        align_chg = 1'b0;
    logic [4:0]  aux_evt = '0;
    logic        ferf_sel5 = 1'b0;
    logic        tmark_sel5 = 1'b0;
    logic        old_rev = 1'b0;
    logic [6:0]  int_en = '0;
    logic [2:0]  st_en = '0;
    logic        src_rd = 1'b0;
    logic        ferf_stat, tmark_val, pld_unstab, ais_stat, irq;
    logic [10:0] int_src;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    e3_maint_monitor uut (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .maint_byte(maint_byte),
        .zero_cnt(zero_cnt), .align_chg(align_chg), .aux_evt(aux_evt),
        .ferf_sel5(ferf_sel5), .tmark_sel5(tmark_sel5), .old_rev(old_rev),
        .int_en(int_en), .st_en(st_en), .src_rd(src_rd), .ferf_stat(ferf_stat),
        .tmark_val(tmark_val), .pld_unstab(pld_unstab), .ais_stat(ais_stat),
        .int_src(int_src), .irq(irq));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; maint_byte = '0; zero_cnt = 8'd20;
        ferf_sel5 = 0; tmark_sel5 = 0; old_rev = 0; int_en = '0; st_en = '0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic frame(input logic [7:0] b, input logic [7:0] z);
        @(negedge clk);
        maint_byte = b; zero_cnt = z; frame_stb = 1'b1;
        @(negedge clk);
        frame_stb = 1'b0;
    endtask

    task automatic read_clear();
        @(negedge clk); src_rd = 1'b1;
        @(negedge clk); src_rd = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R6 reset status", {28'd0, ferf_stat, tmark_val, pld_unstab, ais_stat}, 0);
        chk("R6 reset sources", {21'd0, int_src}, 0);
        chk("R6 reset irq", irq, 0);
    endtask

    task automatic t_ferf3();
        do_reset();
        frame(8'h80, 20); frame(8'h80, 20);
        chk("R1 two ones", ferf_stat, 0);
        frame(8'h80, 20);
        chk("R1 third one", ferf_stat, 1);
        chk("R7 ferf source", int_src[8], 1);
        read_clear();
        frame(8'h00, 20); frame(8'h00, 20); frame(8'h80, 20);
        frame(8'h00, 20); frame(8'h00, 20);
        chk("R2 broken run", ferf_stat, 1);
        chk("R7 no source while held", int_src[8], 0);
        frame(8'h00, 20);
        chk("R2 cleared", ferf_stat, 0);
        chk("R7 ferf clear source", int_src[8], 1);
    endtask

    task automatic t_ferf5();
        do_reset();
        ferf_sel5 = 1;
        for (int i = 0; i < 4; i++) frame(8'h80, 20);
        chk("R1 four of five", ferf_stat, 0);
        frame(8'h80, 20);
        chk("R1 fifth one", ferf_stat, 1);
        for (int i = 0; i < 4; i++) frame(8'h00, 20);
        chk("R2 four zeros", ferf_stat, 1);
        frame(8'h00, 20);
        chk("R2 fifth zero", ferf_stat, 0);
    endtask

    task automatic t_hold();
        do_reset();
        @(negedge clk); maint_byte = 8'h81; zero_cnt = 0;
        repeat (8) @(negedge clk);
        chk("R6 no strobe ferf", ferf_stat, 0);
        chk("R6 no strobe tmark", tmark_val, 0);
        chk("R6 no strobe ais", ais_stat, 0);
    endtask

    task automatic t_tmark();
        do_reset();
        frame(8'h01, 20); frame(8'h01, 20);
        chk("R3 two marks", tmark_val, 0);
        frame(8'h01, 20);
        chk("R3 three marks", tmark_val, 1);
        chk("R7 tmark source", int_src[9], 1);
        tmark_sel5 = 1;
        for (int i = 0; i < 4; i++) frame(8'h00, 20);
        chk("R3 four of five", tmark_val, 1);
        frame(8'h00, 20);
        chk("R3 fifth", tmark_val, 0);
    endtask

    task automatic t_pld();
        do_reset();
        for (int i = 0; i < 5; i++) frame(8'h10, 20);
        chk("R4 steady start", pld_unstab, 0);
        frame(8'h18, 20);
        chk("R4 change", pld_unstab, 1);
        chk("R7 pld source", int_src[10], 1);
        for (int i = 0; i < 3; i++) frame(8'h18, 20);
        chk("R4 window open", pld_unstab, 1);
        frame(8'h18, 20);
        chk("R4 five identical", pld_unstab, 0);
        frame(8'h98, 20);
        chk("R4 other bits ignored", pld_unstab, 0);
    endtask

    task automatic t_ais();
        do_reset();
        frame(8'h00, 6);
        chk("R5 one frame", ais_stat, 0);
        frame(8'h00, 5);
        chk("R5 declared", ais_stat, 1);
        chk("R7 ais source", int_src[0], 1);
        frame(8'h00, 7);
        chk("R5 one clean", ais_stat, 1);
        frame(8'h00, 9);
        chk("R5 cleared", ais_stat, 0);
        frame(8'h00, 7); frame(8'h00, 7);
        chk("R5 boundary seven", ais_stat, 0);
    endtask

    task automatic t_irq();
        do_reset();
        @(negedge clk); aux_evt = 5'b00001;
        @(negedge clk); aux_evt = '0;
        chk("R10 los source", {21'd0, int_src}, 11'h002);
        chk("R9 disabled", irq, 0);
        int_en = 7'h02; #1;
        chk("R9 enabled", irq, 1);
        read_clear();
        chk("R8 cleared", {21'd0, int_src}, 0);
        chk("R9 irq after clear", irq, 0);
        int_en = 7'h60; old_rev = 1;
        @(negedge clk); aux_evt = 5'b11000;
        @(negedge clk); aux_evt = '0;
        chk("R10 ssm sources", {21'd0, int_src}, 11'h060);
        chk("R9 old rev masked", irq, 0);
        old_rev = 0; #1;
        chk("R9 new rev", irq, 1);
    endtask

    task automatic t_collide();
        do_reset();
        @(negedge clk); aux_evt = 5'b00110;
        @(negedge clk); aux_evt = '0; src_rd = 1; align_chg = 1;
        @(negedge clk); src_rd = 0; align_chg = 0;
        chk("R8 set wins", {21'd0, int_src}, 11'h010);
        read_clear();
        frame(8'h00, 0);
        @(negedge clk);
        maint_byte = 8'h00; zero_cnt = 0; frame_stb = 1; aux_evt = 5'b00100;
        @(negedge clk); frame_stb = 0; aux_evt = '0;
        chk("R10 event with strobe", {21'd0, int_src}, 11'h009);
        chk("R5 ais with event", ais_stat, 1);
    endtask

    initial begin
        #3_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_ferf3();
        t_ferf5();
        t_hold();
        t_tmark();
        t_pld();
        t_ais();
        t_irq();
        t_collide();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule